// File: doc/BRIEF.md
# Bus-Attached Serial Port

This block is a memory-mapped asynchronous serial port that hangs off an AHB-Lite slave port. It has one transmit line and one receive line. Each carries 8-bit characters framed by a low start bit and a high stop bit. Software programs the bit time as a count of system clock cycles in a scaler register. A write to the data slot sends one character. A read of the data slot returns the most recently received character.

A three-bit status word lets software poll the port. It reports three things separately: the transmitter is busy, the receiver is inside a frame, and a received character is waiting. Reading the data slot clears the waiting flag. The bus side answers every transfer with zero wait states. Register offsets are taken directly from the address as small integers.

The transmitter uses four states: `TX_IDLE`, `TX_START`, `TX_DATA` and `TX_STOP`. Its transitions are:
- `TX_IDLE` to `TX_START` on an accepted data write.
- `TX_START` to `TX_DATA`, `TX_DATA` to `TX_STOP` and `TX_STOP` to `TX_IDLE`, each when the bit timer expires. The `TX_DATA` exit also requires the eighth bit to have been sent.

The receiver uses five states: `RX_IDLE`, `RX_START`, `RX_DATA`, `RX_STOP` and `RX_BREAK`. Its transitions are:
- `RX_IDLE` to `RX_START` when the synchronised line goes low.
- `RX_START` to `RX_DATA` if the line is still low at mid-bit. Otherwise it returns to `RX_IDLE`.
- `RX_DATA` to `RX_STOP` after the eighth mid-bit sample.
- `RX_STOP` to `RX_IDLE` on a high stop sample, which stores the character. A low stop sample moves it to `RX_BREAK`.
- `RX_BREAK` to `RX_IDLE` once the line is high again.

Top module: `serial_port_ahb`

## Requirements
- R1: After reset, `txd` is high, the status word reads 0 and the data slot reads 0.
- R2: `hready` is always 1 and `hresp` always 0. A transfer is taken only when `hsel` is 1 and `htrans` is NONSEQ (2'b10). Any other transfer changes nothing.
- R3: Write offsets are 0 for transmit data, 1 for control and 2 for scaler. A control write has no effect. Read offsets are 0 for received data and 1 for status, laid out as bit0 data-available, bit1 sending and bit2 receiving. Every other read offset returns 0.
- R4: A sent frame is start (0), eight data bits LSB first, then stop (1). Each bit lasts S cycles, where S is the scaler. `txd` goes low in the cycle after the write's data-phase clock edge. The line is high when idle.
- R5: The sending flag is 1 from the data-phase edge of the write until 10*S cycles later, and 0 afterwards.
- R6: A data write while sending is set is ignored. The running frame is unchanged and no second frame follows.
- R7: The scaler resets to 8. A scaler write is ignored if its value is 0 or does not fit in 16 bits.
- R8: The receiver passes `rxd` through two flip-flops. It confirms the start bit at mid-bit and samples each data bit at mid-bit. The receiving flag is 1 while a frame is in progress.
- R9: After a high stop sample, the receiving flag drops, data-available is set and the data slot returns the received byte.
- R10: A read of the data slot clears data-available. The byte remains readable afterwards.
- R11: A frame whose stop sample is low is discarded. Data-available and the stored byte stay unchanged, and the receiver waits for a high line before looking for the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select, address phase |
| haddr | input | ADDR_W | Register offset, address phase |
| htrans | input | 2 | Transfer type, address phase |
| hwrite | input | 1 | 1 for write, address phase |
| hwdata | input | DATA_W | Write data, data phase |
| hrdata | output | DATA_W | Read data, data phase |
| hready | output | 1 | Always high |
| hresp | output | 1 | Always OKAY (0) |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
The hardest cases to reach from the ports lie in timing windows.
- A data write that lands while the transmitter is busy. The bench places two writes back to back, so the second data phase falls two cycles into the first frame.
- A stop bit that is sampled low. The bench sends a frame with a low stop level and then checks that a clean frame afterwards is still received.
- A status read that falls mid-frame. A forked read is timed to land two bit times into each received frame.

Random scalers and bytes from a fixed seed cover the mid-bit sampling points at both odd and even bit lengths.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int CHAR_W     = 8;
    localparam int CNT_W      = $clog2(CHAR_W);
    localparam int OFF_DATA   = 0;
    localparam int OFF_CTRL   = 1;
    localparam int OFF_SCALER = 2;
    localparam int OFF_STATUS = 1;
    localparam int ST_AVAIL   = 0;
    localparam int ST_SEND    = 1;
    localparam int ST_RECV    = 2;
    localparam logic [1:0] HTRANS_NONSEQ = 2'b10;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BREAK} rx_state_t;
endpackage

// File: rtl/sp_ahb_regs.sv
module sp_ahb_regs
    import sp_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32,
    parameter int SCALER_W   = 16,
    parameter int DEF_SCALER = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hsel,
    input  logic [ADDR_W-1:0]   haddr,
    input  logic [1:0]          htrans,
    input  logic                hwrite,
    input  logic [DATA_W-1:0]   hwdata,
    output logic [DATA_W-1:0]   hrdata,
    input  logic                tx_busy,
    input  logic                rx_busy,
    input  logic                rx_avail,
    input  logic [CHAR_W-1:0]   rx_byte,
    output logic                tx_start,
    output logic [CHAR_W-1:0]   tx_byte,
    output logic [SCALER_W-1:0] scaler,
    output logic                rd_clear
);
    logic              dp_valid_q;
    logic              dp_write_q;
    logic [ADDR_W-1:0] dp_off_q;
    logic              wr_go, rd_go, scaler_ok;

    // address phase capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_valid_q <= 1'b0;
            dp_write_q <= 1'b0;
            dp_off_q   <= '0;
        end else begin
            dp_valid_q <= hsel && (htrans == HTRANS_NONSEQ);
            dp_write_q <= hwrite;
            dp_off_q   <= haddr;
        end
    end

    assign wr_go     = dp_valid_q && dp_write_q;
    assign rd_go     = dp_valid_q && !dp_write_q;
    assign scaler_ok = (hwdata != '0) && ((hwdata >> SCALER_W) == '0);

    always_comb begin
        tx_start = 1'b0;
        if (wr_go && !tx_busy && dp_off_q == ADDR_W'(OFF_DATA))
            tx_start = 1'b1;
    end
    assign tx_byte  = hwdata[CHAR_W-1:0];
    assign rd_clear = rd_go && (dp_off_q == ADDR_W'(OFF_DATA));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            scaler <= SCALER_W'(DEF_SCALER);
        else if (wr_go && dp_off_q == ADDR_W'(OFF_SCALER) && scaler_ok)
            scaler <= hwdata[SCALER_W-1:0];
    end

    // data phase read mux; control offset (OFF_CTRL) is write-only with no effect
    always_comb begin
        hrdata = '0;
        if (rd_go) begin
            if (dp_off_q == ADDR_W'(OFF_DATA)) begin
                hrdata[CHAR_W-1:0] = rx_byte;
            end else if (dp_off_q == ADDR_W'(OFF_STATUS)) begin
                hrdata[ST_AVAIL] = rx_avail;
                hrdata[ST_SEND]  = tx_busy;
                hrdata[ST_RECV]  = rx_busy;
            end
        end
    end
endmodule

// File: rtl/sp_tx.sv
module sp_tx
    import sp_pkg::*;
#(
    parameter int SCALER_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CHAR_W-1:0]   byte_in,
    input  logic [SCALER_W-1:0] scaler,
    output logic                busy,
    output logic                txd
);
    tx_state_t           st_q, st_d;
    logic [SCALER_W-1:0] timer_q, len_q;
    logic [CNT_W-1:0]    bits_q;
    logic [CHAR_W-1:0]   sh_q;
    logic                tick;

    assign tick = (timer_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE:  if (start) st_d = TX_START;
            TX_START: if (tick) st_d = TX_DATA;
            TX_DATA:  if (tick && bits_q == CNT_W'(CHAR_W-1)) st_d = TX_STOP;
            TX_STOP:  if (tick) st_d = TX_IDLE;
            default:  st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q <= '0;
            len_q   <= '0;
            bits_q  <= '0;
            sh_q    <= '0;
        end else if (st_q == TX_IDLE) begin
            if (start) begin
                sh_q    <= byte_in;
                len_q   <= scaler;
                timer_q <= scaler - 1'b1;
                bits_q  <= '0;
            end
        end else if (tick) begin
            timer_q <= len_q - 1'b1;
            if (st_q == TX_DATA) begin
                sh_q   <= sh_q >> 1;
                bits_q <= bits_q + 1'b1;
            end
        end else begin
            timer_q <= timer_q - 1'b1;
        end
    end

    always_comb begin
        busy = (st_q != TX_IDLE);
        unique case (st_q)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh_q[0];
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import sp_pkg::*;
#(
    parameter int SCALER_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rxd,
    input  logic [SCALER_W-1:0] scaler,
    input  logic                clear,
    output logic                busy,
    output logic                avail,
    output logic [CHAR_W-1:0]   data_out
);
    rx_state_t           st_q, st_d;
    logic                s1_q, s2_q;
    logic [SCALER_W-1:0] timer_q, len_q;
    logic [CNT_W-1:0]    bits_q;
    logic [CHAR_W-1:0]   sh_q;
    logic                tick, got_char;

    assign tick     = (timer_q == '0);
    assign got_char = (st_q == RX_STOP) && tick && s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= rxd;
            s2_q <= s1_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_IDLE:  if (!s2_q) st_d = RX_START;
            RX_START: if (tick) st_d = s2_q ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick && bits_q == CNT_W'(CHAR_W-1)) st_d = RX_STOP;
            RX_STOP:  if (tick) st_d = s2_q ? RX_IDLE : RX_BREAK;
            RX_BREAK: if (s2_q) st_d = RX_IDLE;
            default:  st_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q <= '0;
            len_q   <= '0;
            bits_q  <= '0;
            sh_q    <= '0;
        end else begin
            unique case (st_q)
                RX_IDLE: begin
                    len_q   <= scaler;
                    timer_q <= (scaler - 1'b1) >> 1;
                    bits_q  <= '0;
                end
                RX_START, RX_STOP: begin
                    if (tick) timer_q <= len_q - 1'b1;
                    else      timer_q <= timer_q - 1'b1;
                end
                RX_DATA: begin
                    if (tick) begin
                        timer_q <= len_q - 1'b1;
                        sh_q    <= {s2_q, sh_q[CHAR_W-1:1]};
                        bits_q  <= bits_q + 1'b1;
                    end else begin
                        timer_q <= timer_q - 1'b1;
                    end
                end
                default: timer_q <= timer_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            avail    <= 1'b0;
            data_out <= '0;
        end else if (got_char) begin
            avail    <= 1'b1;
            data_out <= sh_q;
        end else if (clear) begin
            avail    <= 1'b0;
        end
    end

    always_comb begin
        unique case (st_q)
            RX_START, RX_DATA, RX_STOP: busy = 1'b1;
            default:                    busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/serial_port_ahb.sv
module serial_port_ahb
    import sp_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32,
    parameter int SCALER_W   = 16,
    parameter int DEF_SCALER = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [DATA_W-1:0] hwdata,
    output logic [DATA_W-1:0] hrdata,
    output logic              hready,
    output logic              hresp,
    output logic              txd,
    input  logic              rxd
);
    logic                tx_busy, tx_start, rx_busy, rx_avail, rd_clear;
    logic [CHAR_W-1:0]   tx_byte, rx_byte;
    logic [SCALER_W-1:0] scaler;

    assign hready = 1'b1;
    assign hresp  = 1'b0;

    sp_ahb_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .SCALER_W(SCALER_W), .DEF_SCALER(DEF_SCALER)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hwdata(hwdata), .hrdata(hrdata),
        .tx_busy(tx_busy), .rx_busy(rx_busy), .rx_avail(rx_avail), .rx_byte(rx_byte),
        .tx_start(tx_start), .tx_byte(tx_byte), .scaler(scaler), .rd_clear(rd_clear)
    );

    sp_tx #(.SCALER_W(SCALER_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .byte_in(tx_byte),
        .scaler(scaler), .busy(tx_busy), .txd(txd)
    );

    sp_rx #(.SCALER_W(SCALER_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .scaler(scaler), .clear(rd_clear),
        .busy(rx_busy), .avail(rx_avail), .data_out(rx_byte)
    );
endmodule

// File: rtl/sp_checks.sv
module sp_checks (
    input logic clk,
    input logic rst_n,
    input logic hready,
    input logic hresp,
    input logic txd,
    input logic tx_busy,
    input logic tx_start,
    input logic rx_busy,
    input logic rx_avail,
    input logic rd_clear
);
    // R2
    bus_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hready && !hresp);
    // R4
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd);
    // R5
    send_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(tx_start));
    // R9
    avail_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_avail) |-> $past(rx_busy));
    // R10
    avail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_avail) |-> $past(rd_clear));
endmodule

bind serial_port_ahb sp_checks u_chk (
    .clk(clk), .rst_n(rst_n), .hready(hready), .hresp(hresp), .txd(txd),
    .tx_busy(tx_busy), .tx_start(tx_start), .rx_busy(rx_busy),
    .rx_avail(rx_avail), .rd_clear(rd_clear)
);

// File: tb/serial_port_ahb_tb_top.sv
module serial_port_ahb_tb_top;
    localparam int DEF_S = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel = 1'b0;
    logic [3:0]  haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [31:0] hwdata = '0;
    logic [31:0] hrdata;
    logic        hready, hresp, txd;
    logic        rxd = 1'b1;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    serial_port_ahb dut_i (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hwdata(hwdata), .hrdata(hrdata), .hready(hready),
        .hresp(hresp), .txd(txd), .rxd(rxd)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [9:0] frame_of(input logic [7:0] b);
        return {1'b1, b, 1'b0};
    endfunction

    task automatic ahb_write(input int a, input logic [31:0] d);
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 4'(a);
        @(posedge clk);
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hwdata = d;
        @(posedge clk);
    endtask

    task automatic ahb_read(input int a, output logic [31:0] d);
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b0; haddr = 4'(a);
        @(posedge clk);
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00;
        d = hrdata;
        @(posedge clk);
    endtask

    task automatic tx_capture(input int s, input int off, input logic [7:0] b, input string req);
        logic [9:0] got = '0;
        for (int k = off; k < 10 * s; k++) begin
            if (k > off) @(posedge clk);
            @(negedge clk);
            if (k % s == s / 2) got[k / s] = txd;
        end
        chk(req, {22'd0, got}, {22'd0, frame_of(b)});
    endtask

    task automatic tx_and_status(input logic [7:0] b, input int s, input string req);
        logic [31:0] st;
        ahb_write(0, {24'd0, b});
        ahb_read(1, st);
        chk("R5 sending", st, 32'h2);
        tx_capture(s, 2, b, req);
        ahb_read(1, st);
        chk("R5 done", st, 32'h0);
    endtask

    task automatic rx_send(input logic [7:0] b, input int s, input bit good);
        logic [9:0] f = frame_of(b);
        if (!good) f[9] = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            rxd = f[i];
            repeat (s - 1) @(negedge clk);
        end
        @(negedge clk);
        rxd = 1'b1;
    endtask

    task automatic rx_check(input logic [7:0] b, input int s);
        logic [31:0] st;
        fork
            rx_send(b, s, 1'b1);
            begin
                repeat (2 * s) @(posedge clk);
                ahb_read(1, st);
                chk("R8 receiving", st, 32'h4);
            end
        join
        repeat (3) @(posedge clk);
        ahb_read(1, st);  chk("R9 avail", st, 32'h1);
        ahb_read(0, st);  chk("R9 byte", st, {24'd0, b});
        ahb_read(1, st);  chk("R10 cleared", st, 32'h0);
        ahb_read(0, st);  chk("R10 kept", st, {24'd0, b});
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        logic [31:0] st;
        logic [7:0]  b;
        int          s;
        bit          stayed_high;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 txd", {31'd0, txd}, 32'h1);
        ahb_read(1, st); chk("R1 status", st, 32'h0);
        ahb_read(0, st); chk("R1 data", st, 32'h0);

        // R7 default scaler
        tx_and_status(8'hA5, DEF_S, "R7 default");

        // R2 ignored transfers and constant response
        chk("R2 resp", {30'd0, hready, hresp}, 32'h2);
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b00; hwrite = 1'b1; haddr = 4'd0;
        @(posedge clk); @(negedge clk);
        hsel = 1'b0; hwdata = 32'hFF;
        @(posedge clk); @(negedge clk);
        hsel = 1'b0; htrans = 2'b10; hwrite = 1'b1; haddr = 4'd0;
        @(posedge clk); @(negedge clk);
        htrans = 2'b00; hwrite = 1'b0; hwdata = 32'h81;
        repeat (3) @(negedge clk);
        chk("R2 txd idle", {31'd0, txd}, 32'h1);
        ahb_read(1, st); chk("R2 status", st, 32'h0);

        // R3 control write has no effect, unmapped read is zero
        ahb_write(1, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R3 ctrl txd", {31'd0, txd}, 32'h1);
        ahb_read(1, st); chk("R3 ctrl status", st, 32'h0);
        ahb_read(3, st); chk("R3 unmapped", st, 32'h0);

        // R7 scaler writes
        ahb_write(2, 32'd4);
        tx_and_status(8'h55, 4, "R7 scaler 4");
        ahb_write(2, 32'd0);
        tx_and_status(8'h0F, 4, "R7 zero ignored");
        ahb_write(2, 32'h0001_0000);
        tx_and_status(8'h81, 4, "R7 wide ignored");

        // R6 write while sending
        ahb_write(2, 32'd5);
        ahb_write(0, 32'h3C);
        ahb_write(0, 32'hC3);
        tx_capture(5, 2, 8'h3C, "R6 frame kept");
        stayed_high = 1'b1;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (!txd) stayed_high = 1'b0;
        end
        chk("R6 no second frame", {31'd0, stayed_high}, 32'h1);

        // R8 R9 R10 reception
        ahb_write(2, 32'd4);
        rx_check(8'hAA, 4);

        // R11 bad stop bit
        rx_send(8'h5A, 4, 1'b0);
        repeat (6) @(posedge clk);
        ahb_read(1, st); chk("R11 no avail", st, 32'h0);
        ahb_read(0, st); chk("R11 byte kept", st, 32'hAA);
        rx_check(8'h3E, 4);

        // random mix, R4 and R8
        for (int i = 0; i < 8; i++) begin
            s = 4 + int'($urandom % 6);
            b = 8'($urandom);
            ahb_write(2, 32'(s));
            tx_and_status(b, s, "R4 random");
            rx_check(8'($urandom), s);
        end

        finish_up();
    end
endmodule